// File: doc/BRIEF.md
# Partial-Array Refresh Scheduler

This block produces the sequence of row addresses that a self-refreshing DRAM array needs, and keeps that sequence inside a configurable power-of-two share of the array. Each pulse on the periodic tick input asks for one refresh. The block answers with a row address and a one-cycle valid strobe. It answers unless refresh is disabled by the coverage setting or by deep power-down.

The refreshed region is set by two configuration inputs. One picks the fraction of the array to keep: all, half, quarter, eighth or nothing. The other places that region at the bottom or at the top of the row space. The configuration may change while refresh is running. A row counter continues from its current position when that position is still inside the new region, and jumps to the region base when it is not. A combinational query port reports whether any given row lies outside the refreshed region, which means its contents are not being maintained.

Top module: `par_refresh_sched`

## Requirements
- R1: While reset is asserted and after it is released, ref_valid is 0 and ref_row is 0. The first accepted tick after reset with full coverage issues row 0.
- R2: Coverage code cfg_cov 000 selects all 2^N rows, 001 selects 2^(N-1), 010 selects 2^(N-2) and 011 selects 2^(N-3).
- R3: With cfg_top = 0 the region starts at row 0. With cfg_top = 1 it starts at row 2^N minus the region size, so it ends at the last row.
- R4: Each accepted tick produces ref_valid high for exactly the one cycle after the tick edge, with ref_row holding the issued row.
- R5: Issued rows ascend by one per accepted tick. After the last row of the region, the next issued row is the region base.
- R6: Coverage codes 100 through 111 select no rows. Ticks then produce no strobe, and every row is flagged lost.
- R7: While deep_pd is 1, ticks produce no strobe and do not advance the counter. After deep_pd returns to 0, the next issued row is the one that would have come next.
- R8: chk_lost is 1 exactly when chk_row is outside the currently configured region. It follows a configuration change in the same cycle.
- R9: When the region is enlarged and the counter is still inside it, counting continues from the counter. The added rows are included from the next tick.
- R10: When a configuration change leaves the counter outside the new region, the next accepted tick issues the region base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cov | input | 3 | Coverage code (fraction of array kept) |
| cfg_top | input | 1 | Region anchor: 0 bottom, 1 top |
| deep_pd | input | 1 | Deep power-down active; suppresses refresh |
| tick | input | 1 | Periodic refresh request, one cycle per request |
| ref_row | output | ROW_BITS | Row address of the issued refresh |
| ref_valid | output | 1 | One-cycle strobe for ref_row |
| chk_row | input | ROW_BITS | Row to classify |
| chk_lost | output | 1 | chk_row lies outside the refreshed region |

## Verification
The hardest situation to reach is a live reconfiguration that lands the counter in a particular place relative to the new region. The counter may end up outside the region, which forces a restart at the base. It may also end up inside an enlarged region, where it must simply continue. The stimulus table chains configurations so that the tick count of each entry leaves the counter at a known row before the next entry. A half-top region then follows a counter sitting low in the array. A shrink to a top quarter follows a counter just below that quarter. An enlargement is then applied while the counter sits mid-quarter. A bench-side reference counter, driven only by the requirement rules, supplies the expected row for every tick.

// File: rtl/par_pkg.sv
// Package: shared coverage codes for the partial-array refresh scheduler.
// Assumes codes at or above COV_NONE all mean "refresh nothing".
package par_pkg;
    typedef enum logic [2:0] {
        COV_FULL    = 3'd0,
        COV_HALF    = 3'd1,
        COV_QUARTER = 3'd2,
        COV_EIGHTH  = 3'd3,
        COV_NONE    = 3'd4
    } cov_e;
endpackage

// File: rtl/par_range_decode.sv
// par_range_decode: turns the coverage code and the anchor bit into a region
// base and an offset mask (region size minus one). Assumes ROW_BITS >= 3, so
// that the eighth-array region is at least one row.
module par_range_decode #(
    parameter int ROW_BITS = 10
) (
    input  logic [2:0]          cov,
    input  logic                top,
    output logic [ROW_BITS-1:0] base,
    output logic [ROW_BITS-1:0] mask,
    output logic                none
);
    import par_pkg::*;
    localparam logic [ROW_BITS-1:0] ALL_ONES = {ROW_BITS{1'b1}};

    // Decode the fraction into a mask, and the anchor into a base.
    always_comb begin
        none = (cov >= COV_NONE);
        mask = ALL_ONES >> cov[1:0];
        base = top ? ~mask : '0;
    end
endmodule

// File: rtl/par_row_counter.sv
// par_row_counter: holds the sweep position. It offers the row to refresh now
// (the counter when it is inside the region, otherwise the region base), and
// advances with wrap on adv. Assumes base is aligned to mask + 1.
module par_row_counter #(
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [ROW_BITS-1:0] base,
    input  logic [ROW_BITS-1:0] mask,
    output logic [ROW_BITS-1:0] issue_row
);
    localparam logic [ROW_BITS-1:0] ONE = {{(ROW_BITS-1){1'b0}}, 1'b1};

    logic [ROW_BITS-1:0] cnt;
    logic [ROW_BITS-1:0] inc;
    logic                in_rng;

    // Choose the row to issue and its wrapped successor.
    always_comb begin
        in_rng    = ((cnt & ~mask) == base);
        issue_row = in_rng ? cnt : base;
        inc       = ((issue_row + ONE) & mask) | base;
    end

    // Step the sweep position once per accepted refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= inc;
    end
endmodule

// File: rtl/par_lost_flag.sv
// par_lost_flag: classifies one row as refreshed or lost under the current
// configuration. Purely combinational.
module par_lost_flag #(
    parameter int ROW_BITS = 10
) (
    input  logic [ROW_BITS-1:0] row,
    input  logic [ROW_BITS-1:0] base,
    input  logic [ROW_BITS-1:0] mask,
    input  logic                none,
    output logic                lost
);
    // A row is lost when coverage is none or its high bits miss the base.
    always_comb lost = none | ((row & ~mask) != base);
endmodule

// File: rtl/par_refresh_sched.sv
// par_refresh_sched: issues one refresh row per accepted tick inside a
// power-of-two region anchored at either end of a 2^ROW_BITS-row array.
// It also flags queried rows outside that region. Configuration may change
// at any time. Assumes tick is a single-cycle request.
module par_refresh_sched #(
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_cov,
    input  logic                cfg_top,
    input  logic                deep_pd,
    input  logic                tick,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                ref_valid,
    input  logic [ROW_BITS-1:0] chk_row,
    output logic                chk_lost
);
    logic [ROW_BITS-1:0] base;
    logic [ROW_BITS-1:0] mask;
    logic                none;
    logic [ROW_BITS-1:0] issue_row;
    logic                accept;

    par_range_decode #(.ROW_BITS(ROW_BITS)) u_dec (
        .cov (cfg_cov),
        .top (cfg_top),
        .base(base),
        .mask(mask),
        .none(none)
    );

    par_row_counter #(.ROW_BITS(ROW_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (accept),
        .base     (base),
        .mask     (mask),
        .issue_row(issue_row)
    );

    par_lost_flag #(.ROW_BITS(ROW_BITS)) u_lost (
        .row (chk_row),
        .base(base),
        .mask(mask),
        .none(none),
        .lost(chk_lost)
    );

    // A tick is served unless power-down or empty coverage blocks it.
    always_comb accept = tick & ~deep_pd & ~none;

    // Register the issued row and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_row   <= '0;
            ref_valid <= 1'b0;
        end else begin
            ref_valid <= accept;
            if (accept) ref_row <= issue_row;
        end
    end
endmodule

// File: rtl/par_sched_chk.sv
// par_sched_chk: temporal checks on the scheduler's ports, bound to every
// instance of par_refresh_sched.
module par_sched_chk #(
    parameter int ROW_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          cfg_cov,
    input logic                cfg_top,
    input logic                deep_pd,
    input logic                tick,
    input logic [ROW_BITS-1:0] ref_row,
    input logic                ref_valid,
    input logic                chk_lost
);
    localparam logic [ROW_BITS-1:0] ALL_ONES = {ROW_BITS{1'b1}};

    logic [2:0]          cov_q;
    logic                top_q;
    logic [ROW_BITS-1:0] m_q;
    logic [ROW_BITS-1:0] b_q;

    // Remember the configuration seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cov_q <= '0;
            top_q <= 1'b0;
        end else begin
            cov_q <= cfg_cov;
            top_q <= cfg_top;
        end
    end

    // Region of the remembered configuration.
    always_comb begin
        m_q = ALL_ONES >> cov_q[1:0];
        b_q = top_q ? ~m_q : '0;
    end

    AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> $past(tick && !deep_pd && cfg_cov < 3'd4)); // R4
    AST_ROW_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> ((ref_row & ~m_q) == b_q)); // R3
    AST_NONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_cov >= 3'd4) |=> !ref_valid); // R6
    AST_NONE_ALL_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cov >= 3'd4) |-> chk_lost); // R6
    AST_DPD_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && deep_pd) |=> !ref_valid); // R7
    AST_ROW_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> (ref_valid || $stable(ref_row))); // R4
endmodule

bind par_refresh_sched par_sched_chk #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cov  (cfg_cov),
    .cfg_top  (cfg_top),
    .deep_pd  (deep_pd),
    .tick     (tick),
    .ref_row  (ref_row),
    .ref_valid(ref_valid),
    .chk_lost (chk_lost)
);

// File: tb/sim_par_refresh_sched.sv
module sim_par_refresh_sched;
    localparam int PERIOD = 10;
    localparam int NB     = 4;
    localparam int NROWS  = 1 << NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_cov = 3'd0;
    logic          cfg_top = 1'b0;
    logic          deep_pd = 1'b0;
    logic          tick = 1'b0;
    logic [NB-1:0] ref_row;
    logic          ref_valid;
    logic [NB-1:0] chk_row = '0;
    logic          chk_lost;

    int checks = 0;
    int errors = 0;
    int mcnt   = 0;

    par_refresh_sched #(.ROW_BITS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cov(cfg_cov), .cfg_top(cfg_top),
        .deep_pd(deep_pd), .tick(tick), .ref_row(ref_row), .ref_valid(ref_valid),
        .chk_row(chk_row), .chk_lost(chk_lost)
    );

    always #(PERIOD/2) clk = ~clk;

    // Stimulus table: {coverage, top anchor, tick count}
    typedef struct packed { logic [2:0] cov; logic top; logic [7:0] n; } vec_t;
    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{3'd0, 1'b0, 8'd18},  // full sweep with wrap (R5)
        '{3'd1, 1'b1, 8'd3},   // counter below half-top region: restart (R10)
        '{3'd2, 1'b1, 8'd5},   // top quarter, restart then wrap (R3)
        '{3'd1, 1'b1, 8'd2},   // enlarge, continue in place (R9)
        '{3'd3, 1'b0, 8'd3},   // bottom eighth (R2)
        '{3'd0, 1'b0, 8'd2},   // enlarge to full (R9)
        '{3'd4, 1'b0, 8'd2},   // none (R6)
        '{3'd2, 1'b0, 8'd4}    // bottom quarter
    };

    function automatic int span_of(input logic [2:0] c);
        return (c >= 3'd4) ? 0 : (NROWS >> c);
    endfunction
    function automatic int base_of(input logic [2:0] c, input logic t);
        return t ? NROWS - span_of(c) : 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference row from the requirement rules; updates the model counter.
    function automatic int model_issue();
        int s = span_of(cfg_cov);
        int b = base_of(cfg_cov, cfg_top);
        int r = (mcnt >= b && mcnt < b + s) ? mcnt : b;
        mcnt = (r + 1 == b + s) ? b : r + 1;
        return r;
    endfunction

    // One tick; checks strobe, row and the pulse width (R4).
    task automatic do_tick(input string tag);
        bit expv = !deep_pd && cfg_cov < 3'd4;
        int er = 0;
        if (expv) er = model_issue();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check(ref_valid == expv, {tag, " R4 strobe"}, ref_valid, expv);
        if (expv) check(ref_row == er[NB-1:0], {tag, " row"}, ref_row, er);
        @(negedge clk);
        check(ref_valid == 1'b0, "R4 pulse width", ref_valid, 0);
    endtask

    // Check the lost flag for every row (R8).
    task automatic sweep_lost();
        int s = span_of(cfg_cov);
        int b = base_of(cfg_cov, cfg_top);
        for (int r = 0; r < NROWS; r++) begin
            bit e = !(r >= b && r < b + s);
            chk_row = r[NB-1:0];
            #1;
            check(chk_lost == e, "R8 lost flag", chk_lost, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ref_valid == 1'b0, "R1 valid in reset", ref_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ref_valid == 1'b0 && ref_row == '0, "R1 after reset", ref_row, 0);
        do_tick("R1 first");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_cov = VT[i].cov;
            cfg_top = VT[i].top;
            sweep_lost();
            for (int k = 0; k < int'(VT[i].n); k++) do_tick("R5 table");
        end

        // Encodings and anchor spot checks (R2, R3)
        cfg_cov = 3'd2; cfg_top = 1'b1;
        chk_row = 4'd11; #1;
        check(chk_lost == 1'b1, "R3 row 11 outside top quarter", chk_lost, 1);
        chk_row = 4'd12; #1;
        check(chk_lost == 1'b0, "R3 row 12 inside top quarter", chk_lost, 0);
        cfg_cov = 3'd3; cfg_top = 1'b0;
        chk_row = 4'd1; #1;
        check(chk_lost == 1'b0, "R2 eighth keeps row 1", chk_lost, 0);
        chk_row = 4'd2; #1;
        check(chk_lost == 1'b1, "R2 eighth drops row 2", chk_lost, 1);

        // Codes above none behave as none (R6)
        cfg_cov = 3'd7;
        sweep_lost();
        do_tick("R6 code 111");

        // Deep power-down freezes the counter (R7)
        cfg_cov = 3'd0; cfg_top = 1'b0;
        do_tick("R7 before");
        deep_pd = 1'b1;
        do_tick("R7 suppressed");
        do_tick("R7 suppressed");
        deep_pd = 1'b0;
        do_tick("R7 resume");

        // Shrink away from counter then enlarge back (R10, R9)
        cfg_cov = 3'd3; cfg_top = 1'b1;
        do_tick("R10 restart");
        cfg_cov = 3'd0;
        do_tick("R9 continue");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule